// File: doc/BRIEF.md
# Dual-Pass Redundant Computation Checker

The block wraps a shared arithmetic unit and guards its results against transient errors by computing every operation more than once. Operand pairs arrive on a valid/ready stream and are collected into a group of `N` entries. The whole group is then issued to the function unit twice, first tagged with phase 0 and then with phase 1. The two passes are compared entry by entry. If any entry disagrees, the whole group is issued a third time, again with phase 0. Each entry's output is then chosen by majority vote.

Results leave on a second valid/ready stream in the order their operands were accepted. Each result carries an error flag and an uncorrectable flag. The function unit is outside the block. The block drives operands and a phase tag, and it samples the result and a returned tag combinationally in the same cycle.

Back-pressure rules:
- Input ready is high only while a group is being collected.
- Input ready falls from the first issue of a group until its last result has been taken.
- The output stream holds its data while ready is low.
- Useful throughput is at most half the raw issue rate.

Top module: `dual_pass_checker`

## Requirements
- R1: After reset, `in_ready`=1, `out_valid`=0 and `fu_valid`=0. An operand pair is accepted on a cycle where `in_valid` and `in_ready` are both 1. After the N-th acceptance, `in_ready` is 0 until the last result of the group has been taken.
- R2: In the cycle after the N-th acceptance, issue starts. Entries are issued in acceptance order, one per cycle, with `fu_phase`=0. The group is then issued again in the same order with `fu_phase`=1. With N=4 the issue order is 1,2,3,4,1,2,3,4.
- R3: When the two passes agree for every entry, `out_sum` equals the (WIDTH+1)-bit sum of the two operands, and `out_err`=0 and `out_uncorr`=0. Results leave in acceptance order.
- R4: If any entry disagrees between the two passes, the whole group is issued a third time, in order, with `fu_phase`=0, before any result is output.
- R5: For an entry whose first two results disagree, `out_err`=1 and `out_sum` is the majority of the three results. When the third result matches the first, the first is chosen; otherwise, when it matches the second, the second is chosen.
- R6: If all three results of an entry differ, `out_uncorr`=1, `out_err`=1 and `out_sum` is the third result.
- R7: A result is counted as disagreeing with every other result when its returned tag `fu_phase_ret` differs from the issued `fu_phase`.
- R8: While `out_valid`=1 and `out_ready`=0, `out_valid`, `out_sum`, `out_err` and `out_uncorr` stay unchanged into the next cycle.
- R9: An entry whose first two results agree gets `out_err`=0 and the first-pass result, even when a third pass runs for another entry and its own third result is wrong.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand pair valid |
| in_ready | output | 1 | Block can accept an operand pair |
| in_a | input | WIDTH | First operand |
| in_b | input | WIDTH | Second operand |
| out_valid | output | 1 | Verified result valid |
| out_ready | input | 1 | Consumer accepts the result |
| out_sum | output | WIDTH+1 | Verified result |
| out_err | output | 1 | First two passes disagreed for this entry |
| out_uncorr | output | 1 | All three passes disagreed |
| fu_valid | output | 1 | An operation is issued this cycle |
| fu_phase | output | 1 | Phase tag of the issued operation |
| fu_a | output | WIDTH | Issued first operand |
| fu_b | output | WIDTH | Issued second operand |
| fu_result | input | WIDTH+1 | Function unit result, same cycle |
| fu_phase_ret | input | 1 | Phase tag returned with the result |

## Verification
The bench drives the following patterns:
- A clean group with carry-out and zero operands checks the plain two-pass path.
- A fault on the second pass and a fault on the first pass separate the two vote branches, since the third result sides with a different pass in each.
- Three distinct faults on one entry expose the uncorrectable case.
- A flipped returned tag with correct data shows that the tag alone forces disagreement.
- A group with a bad third result on an otherwise clean entry checks that entries stay isolated.
- Pseudo-random output back-pressure runs over faulty and clean groups to test holding and ordering.

// File: rtl/rcc_pkg.sv
package rcc_pkg;
  typedef enum logic [2:0] {
    S_FILL  = 3'd0,
    S_P0    = 3'd1,
    S_P1    = 3'd2,
    S_P2    = 3'd3,
    S_DRAIN = 3'd4
  } rcc_state_e;
endpackage

// File: rtl/rcc_seq.sv
module rcc_seq #(
  parameter int N = 4,
  localparam int IDXW = (N > 1) ? $clog2(N) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_fire,
  input  logic                 out_fire,
  input  logic                 go_third,
  output rcc_pkg::rcc_state_e  state,
  output logic [IDXW-1:0]      idx
);
  import rcc_pkg::*;

  logic last;
  assign last = (idx == IDXW'(N - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_FILL;
      idx   <= '0;
    end else begin
      unique case (state)
        S_FILL: if (in_fire) begin
          if (last) begin idx <= '0; state <= S_P0; end
          else idx <= idx + 1'b1;
        end
        S_P0: begin
          if (last) begin idx <= '0; state <= S_P1; end
          else idx <= idx + 1'b1;
        end
        S_P1: begin
          if (last) begin
            idx   <= '0;
            state <= go_third ? S_P2 : S_DRAIN;
          end else idx <= idx + 1'b1;
        end
        S_P2: begin
          if (last) begin idx <= '0; state <= S_DRAIN; end
          else idx <= idx + 1'b1;
        end
        S_DRAIN: if (out_fire) begin
          if (last) begin idx <= '0; state <= S_FILL; end
          else idx <= idx + 1'b1;
        end
        default: begin state <= S_FILL; idx <= '0; end
      endcase
    end
  end
endmodule

// File: rtl/rcc_buffer.sv
module rcc_buffer #(
  parameter int N = 4,
  parameter int WIDTH = 8,
  localparam int IDXW = (N > 1) ? $clog2(N) : 1,
  localparam int RW = WIDTH + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDXW-1:0]  idx,
  input  logic             wr_op,
  input  logic [WIDTH-1:0] op_a_in,
  input  logic [WIDTH-1:0] op_b_in,
  input  logic             wr_r0,
  input  logic             wr_r1,
  input  logic             wr_fin,
  input  logic [RW-1:0]    res_in,
  input  logic             ok_in,
  input  logic             mm_in,
  input  logic [RW-1:0]    fin_in,
  input  logic             unc_in,
  output logic [WIDTH-1:0] rd_a,
  output logic [WIDTH-1:0] rd_b,
  output logic [RW-1:0]    rd_r0,
  output logic             rd_ok0,
  output logic [RW-1:0]    rd_r1,
  output logic             rd_ok1,
  output logic [RW-1:0]    rd_res,
  output logic             rd_mm,
  output logic             rd_unc,
  output logic             any_mm
);
  logic [WIDTH-1:0] op_a [N];
  logic [WIDTH-1:0] op_b [N];
  logic [RW-1:0]    r0   [N];
  logic [RW-1:0]    r1   [N];
  logic [RW-1:0]    res  [N];
  logic [N-1:0]     ok0, ok1, mm, unc;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) begin
        op_a[i] <= '0; op_b[i] <= '0;
        r0[i] <= '0; r1[i] <= '0; res[i] <= '0;
      end
      ok0 <= '0; ok1 <= '0; mm <= '0; unc <= '0;
    end else begin
      if (wr_op) begin
        op_a[idx] <= op_a_in;
        op_b[idx] <= op_b_in;
      end
      if (wr_r0) begin
        r0[idx]  <= res_in;
        ok0[idx] <= ok_in;
        mm[idx]  <= 1'b0;
      end
      if (wr_r1) begin
        r1[idx]  <= res_in;
        ok1[idx] <= ok_in;
        mm[idx]  <= mm_in;
        res[idx] <= r0[idx];
        unc[idx] <= 1'b0;
      end
      if (wr_fin) begin
        res[idx] <= fin_in;
        unc[idx] <= unc_in;
      end
    end
  end

  assign rd_a   = op_a[idx];
  assign rd_b   = op_b[idx];
  assign rd_r0  = r0[idx];
  assign rd_ok0 = ok0[idx];
  assign rd_r1  = r1[idx];
  assign rd_ok1 = ok1[idx];
  assign rd_res = res[idx];
  assign rd_mm  = mm[idx];
  assign rd_unc = unc[idx];
  assign any_mm = |mm;
endmodule

// File: rtl/rcc_vote.sv
module rcc_vote #(
  parameter int RW = 9
) (
  input  logic [RW-1:0] r0,
  input  logic          ok0,
  input  logic [RW-1:0] r1,
  input  logic          ok1,
  input  logic [RW-1:0] r2,
  input  logic          ok2,
  output logic          pair_bad,
  output logic [RW-1:0] voted,
  output logic          uncorr
);
  assign pair_bad = !(ok0 && ok1 && (r0 == r1));

  always_comb begin
    uncorr = 1'b0;
    if (ok2 && ok0 && (r2 == r0))      voted = r0;
    else if (ok2 && ok1 && (r2 == r1)) voted = r1;
    else if (!pair_bad)                voted = r0;
    else begin
      voted  = r2;
      uncorr = 1'b1;
    end
  end
endmodule

// File: rtl/dual_pass_checker.sv
module dual_pass_checker #(
  parameter int N = 4,
  parameter int WIDTH = 8,
  localparam int IDXW = (N > 1) ? $clog2(N) : 1,
  localparam int RW = WIDTH + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [WIDTH-1:0] in_a,
  input  logic [WIDTH-1:0] in_b,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [RW-1:0]    out_sum,
  output logic             out_err,
  output logic             out_uncorr,
  output logic             fu_valid,
  output logic             fu_phase,
  output logic [WIDTH-1:0] fu_a,
  output logic [WIDTH-1:0] fu_b,
  input  logic [RW-1:0]    fu_result,
  input  logic             fu_phase_ret
);
  import rcc_pkg::*;

  rcc_state_e      state;
  logic [IDXW-1:0] idx;
  logic            in_fire, out_fire, go_third;
  logic            ok_now;
  logic [RW-1:0]   rd_r0, rd_r1, rd_res, cmp_r1, voted;
  logic            rd_ok0, rd_ok1, rd_mm, rd_unc, any_mm, cmp_ok1;
  logic            pair_bad, uncorr;

  assign in_ready  = (state == S_FILL);
  assign in_fire   = in_valid && in_ready;
  assign out_valid = (state == S_DRAIN);
  assign out_fire  = out_valid && out_ready;
  assign fu_valid  = (state == S_P0) || (state == S_P1) || (state == S_P2);
  assign fu_phase  = (state == S_P1);
  assign ok_now    = (fu_phase_ret == fu_phase);

  // During the second pass the live result stands in for the stored one.
  assign cmp_r1   = (state == S_P1) ? fu_result : rd_r1;
  assign cmp_ok1  = (state == S_P1) ? ok_now    : rd_ok1;
  assign go_third = any_mm || pair_bad;

  rcc_seq #(.N(N)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_fire  (in_fire),
    .out_fire (out_fire),
    .go_third (go_third),
    .state    (state),
    .idx      (idx)
  );

  rcc_buffer #(.N(N), .WIDTH(WIDTH)) u_buf (
    .clk     (clk),
    .rst_n   (rst_n),
    .idx     (idx),
    .wr_op   (in_fire),
    .op_a_in (in_a),
    .op_b_in (in_b),
    .wr_r0   (state == S_P0),
    .wr_r1   (state == S_P1),
    .wr_fin  (state == S_P2),
    .res_in  (fu_result),
    .ok_in   (ok_now),
    .mm_in   (pair_bad),
    .fin_in  (voted),
    .unc_in  (uncorr),
    .rd_a    (fu_a),
    .rd_b    (fu_b),
    .rd_r0   (rd_r0),
    .rd_ok0  (rd_ok0),
    .rd_r1   (rd_r1),
    .rd_ok1  (rd_ok1),
    .rd_res  (rd_res),
    .rd_mm   (rd_mm),
    .rd_unc  (rd_unc),
    .any_mm  (any_mm)
  );

  rcc_vote #(.RW(RW)) u_vote (
    .r0       (rd_r0),
    .ok0      (rd_ok0),
    .r1       (cmp_r1),
    .ok1      (cmp_ok1),
    .r2       (fu_result),
    .ok2      (ok_now),
    .pair_bad (pair_bad),
    .voted    (voted),
    .uncorr   (uncorr)
  );

  assign out_sum    = rd_res;
  assign out_err    = rd_mm;
  assign out_uncorr = rd_unc;
endmodule

// File: rtl/rcc_checker.sv
module rcc_checker #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_ready,
  input logic             out_valid,
  input logic             out_ready,
  input logic [WIDTH:0]   out_sum,
  input logic             out_err,
  input logic             out_uncorr,
  input logic             fu_valid
);
  a_r1_no_accept_while_output: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_ready && out_valid));

  a_r1_no_accept_while_issue: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_ready && fu_valid));

  a_r4_drain_after_issue: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(fu_valid));

  a_r6_uncorr_implies_err: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_uncorr) |-> out_err);

  a_r8_hold_under_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_sum)
                                   && $stable(out_err) && $stable(out_uncorr)));
endmodule

bind dual_pass_checker rcc_checker #(.WIDTH(WIDTH)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_ready   (in_ready),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .out_sum    (out_sum),
  .out_err    (out_err),
  .out_uncorr (out_uncorr),
  .fu_valid   (fu_valid)
);

// File: tb/sim_dual_pass_checker.sv
module sim_dual_pass_checker;
  localparam int W = 8;
  localparam int N = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [W-1:0] in_a = '0, in_b = '0;
  logic         out_valid;
  logic         out_ready;
  logic [W:0]   out_sum;
  logic         out_err, out_uncorr;
  logic         fu_valid, fu_phase;
  logic [W-1:0] fu_a, fu_b;
  logic [W:0]   fu_result;
  logic         fu_phase_ret;

  int checks = 0;
  int fails = 0;

  logic [W:0] fmask [0:1023];
  logic       tflip [0:1023];
  logic [9:0] issue_cnt;
  int         mcnt = 0;

  dual_pass_checker #(.N(N), .WIDTH(W)) u0 (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_a(in_a), .in_b(in_b),
    .out_valid(out_valid), .out_ready(out_ready), .out_sum(out_sum),
    .out_err(out_err), .out_uncorr(out_uncorr),
    .fu_valid(fu_valid), .fu_phase(fu_phase), .fu_a(fu_a), .fu_b(fu_b),
    .fu_result(fu_result), .fu_phase_ret(fu_phase_ret)
  );

  // Function unit model: adder with per-issue fault injection.
  assign fu_result    = ({1'b0, fu_a} + {1'b0, fu_b}) ^ fmask[issue_cnt];
  assign fu_phase_ret = fu_phase ^ tflip[issue_cnt];

  always @(posedge clk) begin
    if (!rst_n) issue_cnt <= '0;
    else if (fu_valid) issue_cnt <= issue_cnt + 1'b1;
  end

  typedef struct { logic [W-1:0] a; logic [W-1:0] b; logic ph; } iss_t;
  typedef struct { logic [W:0] s; logic e; logic u; } out_t;
  iss_t iss_q[$];
  out_t out_q[$];
  logic [W-1:0] grp_a [0:N-1];
  logic [W-1:0] grp_b [0:N-1];

  task automatic chk(input bit ok, input string req, input string what);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: %s", req, what);
    end
  endtask

  task automatic set_fault(input int pass, input int op, input logic [W:0] m, input bit f);
    fmask[mcnt + pass*N + op] = m;
    tflip[mcnt + pass*N + op] = f;
  endtask

  // Behavioural expectation for one group, built from the requirements.
  task automatic model_group();
    logic [W:0] r  [0:2][0:N-1];
    bit         ok [0:2][0:N-1];
    bit         mm [0:N-1];
    bit         any = 0;
    for (int p = 0; p < 2; p++)
      for (int i = 0; i < N; i++) begin
        int k = mcnt + p*N + i;
        iss_t it;
        it.a = grp_a[i]; it.b = grp_b[i]; it.ph = (p == 1);
        iss_q.push_back(it);
        r[p][i]  = ({1'b0, grp_a[i]} + {1'b0, grp_b[i]}) ^ fmask[k];
        ok[p][i] = !tflip[k];
      end
    for (int i = 0; i < N; i++) begin
      mm[i] = !(ok[0][i] && ok[1][i] && r[0][i] == r[1][i]);
      if (mm[i]) any = 1;
    end
    if (any)
      for (int i = 0; i < N; i++) begin
        int k = mcnt + 2*N + i;
        iss_t it;
        it.a = grp_a[i]; it.b = grp_b[i]; it.ph = 1'b0;
        iss_q.push_back(it);
        r[2][i]  = ({1'b0, grp_a[i]} + {1'b0, grp_b[i]}) ^ fmask[k];
        ok[2][i] = !tflip[k];
      end
    for (int i = 0; i < N; i++) begin
      out_t o;
      o.e = mm[i]; o.u = 1'b0; o.s = r[0][i];
      if (mm[i]) begin
        if (ok[2][i] && ok[0][i] && r[2][i] == r[0][i])      o.s = r[0][i];
        else if (ok[2][i] && ok[1][i] && r[2][i] == r[1][i]) o.s = r[1][i];
        else begin o.s = r[2][i]; o.u = 1'b1; end
      end
      out_q.push_back(o);
    end
    mcnt += (any ? 3 : 2) * N;
  endtask

  task automatic load(input logic [W-1:0] a0, a1, a2, a3, b0, b1, b2, b3);
    grp_a[0] = a0; grp_a[1] = a1; grp_a[2] = a2; grp_a[3] = a3;
    grp_b[0] = b0; grp_b[1] = b1; grp_b[2] = b2; grp_b[3] = b3;
  endtask

  task automatic send_group();
    model_group();
    for (int i = 0; i < N; i++) begin
      in_valid = 1'b1; in_a = grp_a[i]; in_b = grp_b[i];
      while (!in_ready) @(negedge clk);
      @(negedge clk);
    end
    // R1/R2: right after the N-th acceptance, input closes and phase-0 issue starts.
    chk(!in_ready, "R1", $sformatf("in_ready=%0b expected 0", in_ready));
    chk(fu_valid && !fu_phase, "R2",
        $sformatf("fu_valid=%0b fu_phase=%0b expected 1/0", fu_valid, fu_phase));
    in_valid = 1'b0;
  endtask

  // Monitor: issue order, output values, stall holding.
  logic [15:0] lfsr = 16'hACE1;
  bit          bp = 0;
  bit          hold_v = 0;
  logic [W:0]  hold_s;
  logic        hold_e, hold_u;
  iss_t        ie;
  out_t        oe;
  string       rq;

  always @(negedge clk) begin
    if (!rst_n) begin
      out_ready = 1'b1;
      hold_v = 0;
    end else begin
      if (fu_valid) begin
        if (iss_q.size() == 0) chk(0, "R4", "unexpected issue with empty expectation");
        else begin
          ie = iss_q.pop_front();
          chk(fu_a == ie.a && fu_b == ie.b && fu_phase == ie.ph, "R2",
              $sformatf("issue a=%0d b=%0d ph=%0b expected a=%0d b=%0d ph=%0b",
                        fu_a, fu_b, fu_phase, ie.a, ie.b, ie.ph));
        end
      end
      if (hold_v)
        chk(out_valid && out_sum == hold_s && out_err == hold_e && out_uncorr == hold_u, "R8",
            $sformatf("stalled v=%0b sum=%0d err=%0b unc=%0b expected 1/%0d/%0b/%0b",
                      out_valid, out_sum, out_err, out_uncorr, hold_s, hold_e, hold_u));
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      out_ready = bp ? lfsr[0] : 1'b1;
      if (out_valid && out_ready) begin
        if (out_q.size() == 0) chk(0, "R3", "unexpected output with empty expectation");
        else begin
          oe = out_q.pop_front();
          rq = oe.u ? "R6" : (oe.e ? "R5" : "R3");
          chk(out_sum == oe.s && out_err == oe.e && out_uncorr == oe.u, rq,
              $sformatf("out sum=%0d err=%0b unc=%0b expected sum=%0d err=%0b unc=%0b",
                        out_sum, out_err, out_uncorr, oe.s, oe.e, oe.u));
        end
      end
      hold_v = out_valid && !out_ready;
      hold_s = out_sum; hold_e = out_err; hold_u = out_uncorr;
    end
  end

  task automatic wait_idle();
    while (out_q.size() != 0 || iss_q.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  bit timed_out = 0;

  initial begin
    for (int i = 0; i < 1024; i++) begin fmask[i] = '0; tflip[i] = 1'b0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(in_ready && !out_valid && !fu_valid, "R1",
        $sformatf("reset ready=%0b out_valid=%0b fu_valid=%0b expected 1/0/0",
                  in_ready, out_valid, fu_valid));
    fork
      begin
        // Clean group with carry-out and zero operands (R3).
        load(255, 0, 17, 128, 255, 0, 40, 127);
        send_group();
        wait_idle();
        // Second pass fault on entry 2: third agrees with first (R4, R5).
        load(1, 2, 3, 4, 10, 20, 30, 40);
        set_fault(1, 2, 9'h001, 0);
        send_group();
        wait_idle();
        // First pass fault on entry 1: third agrees with second (R5).
        load(9, 8, 7, 6, 5, 4, 3, 2);
        set_fault(0, 1, 9'h010, 0);
        send_group();
        wait_idle();
        // All three passes differ on entry 3 (R6).
        load(100, 101, 102, 103, 50, 51, 52, 53);
        set_fault(0, 3, 9'h001, 0);
        set_fault(1, 3, 9'h002, 0);
        set_fault(2, 3, 9'h004, 0);
        send_group();
        wait_idle();
        // Returned tag flipped on second pass of entry 0, data intact (R7).
        load(11, 22, 33, 44, 1, 1, 1, 1);
        set_fault(1, 0, 9'h000, 1);
        send_group();
        wait_idle();
        // Third pass wrong on a clean entry stays isolated (R9).
        load(60, 61, 62, 63, 70, 71, 72, 73);
        set_fault(1, 0, 9'h080, 0);
        set_fault(2, 2, 9'h100, 0);
        send_group();
        wait_idle();
        // Back-pressure over faulty and clean groups, sent back to back (R8).
        bp = 1;
        load(200, 201, 202, 203, 100, 99, 98, 97);
        set_fault(0, 0, 9'h003, 0);
        send_group();
        load(5, 6, 7, 8, 250, 251, 252, 253);
        send_group();
        load(0, 1, 0, 1, 0, 0, 1, 1);
        set_fault(1, 3, 9'h000, 1);
        set_fault(2, 3, 9'h000, 1);
        send_group();
        wait_idle();
        bp = 0;
        @(negedge clk);
        chk(in_ready && !out_valid && !fu_valid, "R1",
            $sformatf("idle ready=%0b out_valid=%0b fu_valid=%0b expected 1/0/0",
                      in_ready, out_valid, fu_valid));
      end
      begin
        repeat (20000) @(posedge clk);
        timed_out = 1;
      end
    join_any
    disable fork;
    if (timed_out) chk(0, "R1", "watchdog expired: actual hung, expected completion");
    chk(iss_q.size() == 0 && out_q.size() == 0, "R4",
        $sformatf("pending issues=%0d outputs=%0d expected 0/0", iss_q.size(), out_q.size()));
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule